// File: doc/BRIEF.md
# Conditional Execution Flag Evaluator

This block decides whether an instruction may execute. It takes a 4-bit condition field and tests it against a stored set of arithmetic flags: negative (N), zero (Z), carry (C) and overflow (V). The result is a pass signal for the current instruction. The block also owns the flag register.

When an instruction is valid, asks for a flag update and passes its own condition, the flags produced by the arithmetic unit are captured on the next clock edge. The register also holds a saturation flag and a group of SIMD greater-or-equal bits. These are written together with the arithmetic flags but are never tested.

The condition is always judged against the flags as they stood before the instruction's own write. A pipeline can therefore present a condition and its new flags in the same cycle.

Top module: `ce_flag_evaluator`

## Requirements
- R1: A synchronous active-high reset clears N, Z, C, V, the saturation flag and all greater-or-equal bits to zero.
- R2: Condition code 0000 (equal) passes when Z=1. Code 0001 (not equal) passes when Z=0.
- R3: Code 0010 (carry set) passes when C=1. Code 0011 (carry clear) passes when C=0.
- R4: Code 0100 (minus) passes when N=1. Code 0101 (plus) passes when N=0.
- R5: Code 0110 (overflow) passes when V=1. Code 0111 (no overflow) passes when V=0.
- R6: Code 1000 (unsigned higher) passes when C=1 and Z=0. Code 1001 (unsigned lower-or-same) passes when C=0 or Z=1.
- R7: Code 1010 (signed greater-or-equal) passes when N equals V. Code 1011 (signed less) passes when N differs from V.
- R8: Code 1100 (signed greater) passes when Z=0 and N equals V. Code 1101 (signed less-or-equal) passes when Z=1 or N differs from V.
- R9: Codes 1110 and 1111 always pass.
- R10: On a clock edge the whole flag register (N, Z, C, V, saturation, greater-or-equal) is loaded from the new-flag inputs only when valid, set-flags and pass are all high. In every other case it keeps its value.
- R11: A valid instruction that asks for a flag update but fails its condition leaves every stored flag unchanged.
- R12: The pass output is computed from the flags held before the current instruction's own update. Flags written by an instruction first affect the following cycle.
- R13: The pass output is low whenever the valid strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is present this cycle |
| cond_i | input | 4 | Condition field of the instruction |
| set_flags_i | input | 1 | Instruction requests a flag update |
| new_nzcv_i | input | 4 | New flags from the ALU, bits {N,Z,C,V} from bit 3 down to bit 0 |
| new_sat_i | input | 1 | New saturation flag |
| new_ge_i | input | GE_W | New greater-or-equal bits |
| pass_o | output | 1 | Condition satisfied for the valid instruction |
| nzcv_o | output | 4 | Stored flags {N,Z,C,V} |
| sat_o | output | 1 | Stored saturation flag |
| ge_o | output | GE_W | Stored greater-or-equal bits |

## Verification
Condition evaluation and the flag write can happen in the same cycle. An instruction may test the flags while also rewriting them. The bench provokes this by presenting a condition that passes on the old flags (not equal, with Z clear) together with set-flags and new flags that set Z. It also presents one that fails on the old flags (equal, with Z clear) together with new flags that would make it pass.

The bench samples pass before the edge and reads the stored flags after it. The first case must pass and load Z. The second must fail and leave the register untouched, so a design that tested the incoming flags, or wrote regardless of the result, shows up at the ports.

// File: rtl/ce_pkg.sv
package ce_pkg;

    localparam int NZCV_W = 4;

    typedef enum logic [3:0] {
        C_EQ = 4'b0000,
        C_NE = 4'b0001,
        C_CS = 4'b0010,
        C_CC = 4'b0011,
        C_MI = 4'b0100,
        C_PL = 4'b0101,
        C_VS = 4'b0110,
        C_VC = 4'b0111,
        C_HI = 4'b1000,
        C_LS = 4'b1001,
        C_GE = 4'b1010,
        C_LT = 4'b1011,
        C_GT = 4'b1100,
        C_LE = 4'b1101,
        C_AL = 4'b1110,
        C_NV = 4'b1111
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    // Predicate table. The low bit of each pair inverts the base test.
    function automatic logic cond_holds(cond_e cc, nzcv_t f);
        logic base;
        case (cc[3:1])
            3'd0:    base = f.z;
            3'd1:    base = f.c;
            3'd2:    base = f.n;
            3'd3:    base = f.v;
            3'd4:    base = f.c & ~f.z;
            3'd5:    base = ~(f.n ^ f.v);
            3'd6:    base = ~f.z & ~(f.n ^ f.v);
            default: base = 1'b1;
        endcase
        if (cc[3:1] == 3'd7) begin
            return 1'b1;
        end
        return cc[0] ? ~base : base;
    endfunction

endpackage

// File: rtl/ce_cond_eval.sv
module ce_cond_eval
    import ce_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cond_e cond,
    input  nzcv_t flags,
    output logic  holds
);

    assign holds = cond_holds(cond, flags);

    // R2
    eq_ne_chk: assert property (@(posedge clk) disable iff (rst)
        (cond == C_EQ || cond == C_NE) |-> (holds == (flags.z ^ (cond == C_NE))));

    // R6
    hi_chk: assert property (@(posedge clk) disable iff (rst)
        (cond == C_HI) |-> (holds == (flags.c && !flags.z)));

    // R8
    gt_chk: assert property (@(posedge clk) disable iff (rst)
        (cond == C_GT) |-> (holds == (!flags.z && (flags.n == flags.v))));

    // R9
    always_chk: assert property (@(posedge clk) disable iff (rst)
        (cond == C_AL || cond == C_NV) |-> holds);

endmodule

// File: rtl/ce_flag_store.sv
module ce_flag_store
    import ce_pkg::*;
#(
    parameter int GE_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  nzcv_t           nzcv_d,
    input  logic            sat_d,
    input  logic [GE_W-1:0] ge_d,
    output nzcv_t           nzcv_q,
    output logic            sat_q,
    output logic [GE_W-1:0] ge_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            nzcv_q <= '0;
            sat_q  <= 1'b0;
        end else if (wr_en) begin
            nzcv_q <= nzcv_d;
            sat_q  <= sat_d;
        end
    end

    // One register per greater-or-equal lane.
    for (genvar g = 0; g < GE_W; g++) begin : g_ge
        always_ff @(posedge clk) begin
            if (rst) begin
                ge_q[g] <= 1'b0;
            end else if (wr_en) begin
                ge_q[g] <= ge_d[g];
            end
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (nzcv_q == '0 && !sat_q && ge_q == '0));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(nzcv_q) && $stable(sat_q) && $stable(ge_q)));

endmodule

// File: rtl/ce_flag_evaluator.sv
module ce_flag_evaluator
    import ce_pkg::*;
#(
    parameter int GE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [3:0]        cond_i,
    input  logic              set_flags_i,
    input  logic [NZCV_W-1:0] new_nzcv_i,
    input  logic              new_sat_i,
    input  logic [GE_W-1:0]   new_ge_i,
    output logic              pass_o,
    output logic [NZCV_W-1:0] nzcv_o,
    output logic              sat_o,
    output logic [GE_W-1:0]   ge_o
);

    nzcv_t cur_flags;
    logic  holds;
    logic  wr_en;

    ce_cond_eval u_eval (
        .clk   (clk),
        .rst   (rst),
        .cond  (cond_e'(cond_i)),
        .flags (cur_flags),
        .holds (holds)
    );

    assign pass_o = valid_i & holds;
    assign wr_en  = pass_o & set_flags_i;

    ce_flag_store #(.GE_W(GE_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .nzcv_d (nzcv_t'(new_nzcv_i)),
        .sat_d  (new_sat_i),
        .ge_d   (new_ge_i),
        .nzcv_q (cur_flags),
        .sat_q  (sat_o),
        .ge_q   (ge_o)
    );

    assign nzcv_o = cur_flags;

    // R11
    fail_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !pass_o) |=> ($stable(nzcv_o) && $stable(sat_o) && $stable(ge_o)));

    // R12
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && set_flags_i && pass_o) |=> (nzcv_o == $past(new_nzcv_i)));

    // R13
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !pass_o);

endmodule

// File: tb/tb_ce_flag_evaluator.sv
module tb_ce_flag_evaluator;

    localparam int GE_W = 4;

    logic            clk = 1'b0;
    logic            rst;
    logic            valid_i;
    logic [3:0]      cond_i;
    logic            set_flags_i;
    logic [3:0]      new_nzcv_i;
    logic            new_sat_i;
    logic [GE_W-1:0] new_ge_i;
    logic            pass_o;
    logic [3:0]      nzcv_o;
    logic            sat_o;
    logic [GE_W-1:0] ge_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ce_flag_evaluator #(.GE_W(GE_W)) dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .cond_i(cond_i),
        .set_flags_i(set_flags_i), .new_nzcv_i(new_nzcv_i),
        .new_sat_i(new_sat_i), .new_ge_i(new_ge_i), .pass_o(pass_o),
        .nzcv_o(nzcv_o), .sat_o(sat_o), .ge_o(ge_o)
    );

    // {flags NZCV, cond, expected pass}
    localparam logic [8:0] VEC [22] = '{
        {4'b0100, 4'b0000, 1'b1},   // R2 EQ, Z=1
        {4'b0000, 4'b0000, 1'b0},   // R2 EQ, Z=0
        {4'b0000, 4'b0001, 1'b1},   // R2 NE, Z=0
        {4'b0010, 4'b0010, 1'b1},   // R3 CS
        {4'b0010, 4'b0011, 1'b0},   // R3 CC
        {4'b1000, 4'b0100, 1'b1},   // R4 MI
        {4'b1000, 4'b0101, 1'b0},   // R4 PL
        {4'b0001, 4'b0110, 1'b1},   // R5 VS
        {4'b0000, 4'b0111, 1'b1},   // R5 VC
        {4'b0010, 4'b1000, 1'b1},   // R6 HI
        {4'b0110, 4'b1000, 1'b0},   // R6 HI with Z
        {4'b0110, 4'b1001, 1'b1},   // R6 LS with Z
        {4'b0010, 4'b1001, 1'b0},   // R6 LS false
        {4'b1001, 4'b1010, 1'b1},   // R7 GE N=V
        {4'b1000, 4'b1010, 1'b0},   // R7 GE N!=V
        {4'b1000, 4'b1011, 1'b1},   // R7 LT
        {4'b0000, 4'b1100, 1'b1},   // R8 GT
        {4'b0100, 4'b1100, 1'b0},   // R8 GT with Z
        {4'b0100, 4'b1101, 1'b1},   // R8 LE with Z
        {4'b0001, 4'b1101, 1'b1},   // R8 LE N!=V
        {4'b1111, 4'b1110, 1'b1},   // R9 AL
        {4'b0000, 4'b1111, 1'b1}    // R9 code 1111
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issue one instruction at a negedge and leave it on the inputs through the next rising edge.
    task automatic issue(input logic v, input logic [3:0] c, input logic s,
                         input logic [3:0] f, input logic q, input logic [GE_W-1:0] g);
        @(negedge clk);
        valid_i = v; cond_i = c; set_flags_i = s;
        new_nzcv_i = f; new_sat_i = q; new_ge_i = g;
    endtask

    task automatic go_idle();
        @(negedge clk);
        valid_i = 1'b0; set_flags_i = 1'b0; cond_i = 4'b1110;
        new_nzcv_i = '0; new_sat_i = 1'b0; new_ge_i = '0;
    endtask

    task automatic load_flags(input logic [3:0] f);
        issue(1'b1, 4'b1110, 1'b1, f, 1'b0, '0);
        go_idle();
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; cond_i = 4'b1110; set_flags_i = 1'b0;
        new_nzcv_i = 4'hF; new_sat_i = 1'b1; new_ge_i = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 nzcv", nzcv_o, 0);
        check("R1 sat", sat_o, 0);
        check("R1 ge", ge_o, 0);
        rst = 1'b0;
        go_idle();

        for (int i = 0; i < 22; i++) begin
            load_flags(VEC[i][8:5]);
            check("R10 load", nzcv_o, VEC[i][8:5]);
            issue(1'b1, VEC[i][4:1], 1'b0, 4'h0, 1'b0, '0);
            #5;
            check($sformatf("cond %b vec %0d (R2..R9)", VEC[i][4:1], i), pass_o, VEC[i][0]);
            go_idle();
        end

        // R13: valid low forces pass low even for always-pass code
        #5;
        check("R13 idle", pass_o, 0);

        // R10: full register write including saturation and ge bits
        issue(1'b1, 4'b1110, 1'b1, 4'b1010, 1'b1, 4'b0110);
        go_idle();
        check("R10 nzcv", nzcv_o, 4'b1010);
        check("R10 sat", sat_o, 1);
        check("R10 ge", ge_o, 4'b0110);

        // R10: valid without set-flags holds
        issue(1'b1, 4'b1110, 1'b0, 4'b0101, 1'b0, 4'b1001);
        go_idle();
        check("R10 no set nzcv", nzcv_o, 4'b1010);
        check("R10 no set ge", ge_o, 4'b0110);

        // R10: set-flags without valid holds
        issue(1'b0, 4'b1110, 1'b1, 4'b0101, 1'b0, 4'b1001);
        go_idle();
        check("R10 no valid nzcv", nzcv_o, 4'b1010);
        check("R10 no valid sat", sat_o, 1);

        // R11: failed condition blocks write (Z=0, EQ, new flags set Z)
        load_flags(4'b0000);
        issue(1'b1, 4'b0000, 1'b1, 4'b0100, 1'b1, 4'b1111);
        #5;
        check("R11 pass low", pass_o, 0);
        go_idle();
        check("R11 nzcv held", nzcv_o, 4'b0000);
        check("R11 ge held", ge_o, 4'b0000);
        check("R11 sat held", sat_o, 0);

        // R12: NE judged on old Z=0 while writing Z=1
        issue(1'b1, 4'b0001, 1'b1, 4'b0100, 1'b0, '0);
        #5;
        check("R12 old flags pass", pass_o, 1);
        go_idle();
        check("R12 write landed", nzcv_o, 4'b0100);
        issue(1'b1, 4'b0001, 1'b0, 4'b0000, 1'b0, '0);
        #5;
        check("R12 next cycle sees new", pass_o, 0);
        go_idle();

        // R1: reset after flags were set
        load_flags(4'b1111);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 rerst nzcv", nzcv_o, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule